// File: doc/BRIEF.md
# Hash-Rehash Direct-Mapped Cache

This block is a direct-mapped cache that gets close to two-way hit rates with a single line array. Every access first probes the slot chosen by the ordinary index. If that probe misses, a second, sequential probe looks at a partner slot. The partner slot's index is the primary index with its most significant bit inverted.

A hit in the partner slot swaps the two lines, so the block just used now sits in its primary slot. A miss in both probes fetches the whole line from memory and installs it in the primary slot. The former primary occupant moves to the partner slot, and whatever sat in the partner slot is evicted. A dirty evicted line is written back before the fill is requested.

Each line keeps a flag that says whether it sits in its partner slot rather than its own. The flag keeps a line from being matched by the wrong probe, and it lets the full line address be rebuilt at write-back. The CPU side takes one word request at a time. The memory side moves whole lines through a request/acknowledge handshake.

Top module: `hr_cache`

## Requirements
- R1: After reset, req_ready is 1, resp_valid is 0 and mem_req is 0. Every line is invalid, so the first access to any address misses in both probes.
- R2: A request that hits at its primary slot gives resp_valid in the cycle after the one in which it was accepted, with no memory traffic. The primary slot is selected by address bits [OFFSET_W+INDEX_W-1:OFFSET_W]. The word is selected by bits [OFFSET_W-1:0], and the tag is the remaining upper bits.
- R3: A primary miss is followed by a second tag probe at the primary index with its top bit inverted (index 2 pairs with index 6 when INDEX_W is 3).
- R4: A hit in the second probe responds 3 cycles after acceptance and exchanges the two lines. A repeat access to the same address then hits at its primary slot, and the displaced block hits through the second probe.
- R5: A miss in both probes reads the line at mem_addr = req_addr >> OFFSET_W and installs it at the primary slot. The old primary occupant moves to the partner slot, where it stays reachable, and the partner occupant is evicted.
- R6: An evicted dirty line is written to memory at its own line address before the fill read is issued. An evicted clean line causes no memory write.
- R7: A line held in its partner slot never satisfies a primary probe, even for a request whose tag is equal. When a later double miss moves that line back to its own slot, it hits there in one cycle.
- R8: A write replaces only the addressed word and marks the line dirty. A write miss first fetches the line and then merges the word, so the other words keep their memory values.
- R9: mem_req, mem_we and mem_addr hold steady until mem_ack. One mem_ack pulse completes one line transfer.
- R10: resp_valid is a one-cycle pulse, and req_ready stays low from acceptance until the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Cache idle, request taken on this edge |
| req_write | input | 1 | 1 = store word, 0 = load word |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | WORD_W | Store data |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_rdata | output | WORD_W | Addressed word (new value on stores) |
| mem_req | output | 1 | Memory line transfer requested |
| mem_we | output | 1 | 1 = write-back, 0 = fill read |
| mem_addr | output | ADDR_W-OFFSET_W | Line address |
| mem_wdata | output | WORD_W*2**OFFSET_W | Write-back line |
| mem_ack | input | 1 | Transfer done (read data valid) |
| mem_rdata | input | WORD_W*2**OFFSET_W | Fill line |

## Verification
The bench first sends two blocks that share one index pair back and forth. A design that omits the swap keeps paying the 3-cycle second-probe latency on the hot block, and one that swaps wrongly returns stale words. It then brings a dirty block back after two further conflicting misses have pushed it out. A missing or misaddressed write-back shows up as the old memory word instead of the stored one. A request with the same tag as a line parked in its partner slot catches a design that ignores the residence flag, because it would report a false one-cycle hit. The final case is a write miss, and a fill that is not merged overwrites either the new word or its neighbour.

// File: rtl/hr_pkg.sv
package hr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOK1, ST_LOOK2, ST_SWAP, ST_WB, ST_FILL
  } hr_state_t;

  // per-line flags held next to the tag: valid, dirty, parked-in-partner
  localparam int FLAG_W = 3;
endpackage

// File: rtl/hr_line_store.sv
module hr_line_store #(
  parameter int INDEX_W = 3,
  parameter int META_W  = 11,
  parameter int LINE_W  = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INDEX_W-1:0] a_idx,
  output logic [META_W-1:0]  a_meta,
  output logic [LINE_W-1:0]  a_data,
  input  logic [INDEX_W-1:0] b_idx,
  output logic [META_W-1:0]  b_meta,
  output logic [LINE_W-1:0]  b_data,
  input  logic               wa_en,
  input  logic [META_W-1:0]  wa_meta,
  input  logic [LINE_W-1:0]  wa_data,
  input  logic               wb_en,
  input  logic [META_W-1:0]  wb_meta,
  input  logic [LINE_W-1:0]  wb_data
);
  localparam int LINES = 1 << INDEX_W;

  logic [META_W-1:0] meta_q [LINES];
  logic [LINE_W-1:0] data_q [LINES];

  assign a_meta = meta_q[a_idx];
  assign a_data = data_q[a_idx];
  assign b_meta = meta_q[b_idx];
  assign b_data = data_q[b_idx];

  // tags and flags: reset clears valid
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) meta_q[i] <= '0;
    end else begin
      if (wa_en) meta_q[a_idx] <= wa_meta;
      if (wb_en) meta_q[b_idx] <= wb_meta;
    end
  end

  // line payload: no reset so it can map onto a RAM
  always_ff @(posedge clk) begin
    if (wa_en) data_q[a_idx] <= wa_data;
    if (wb_en) data_q[b_idx] <= wb_data;
  end

  // R4
  port_a_rdwr_chk: assert property (@(posedge clk) disable iff (rst)
    wa_en |=> (a_idx != $past(a_idx)) || (a_meta == $past(wa_meta)));
  // R5
  port_b_rdwr_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_en && (a_idx != b_idx)) |=> (b_idx != $past(b_idx)) || (b_meta == $past(wb_meta)));
endmodule

// File: rtl/hr_tag_cmp.sv
module hr_tag_cmp #(
  parameter int TAG_W = 8
) (
  input  logic             line_valid,
  input  logic             line_parked,
  input  logic [TAG_W-1:0] line_tag,
  input  logic             want_parked,
  input  logic [TAG_W-1:0] want_tag,
  output logic             hit
);
  assign hit = line_valid && (line_parked == want_parked) && (line_tag == want_tag);
endmodule

// File: rtl/hr_word_merge.sv
module hr_word_merge #(
  parameter int WORD_W   = 32,
  parameter int OFFSET_W = 1
) (
  input  logic [WORD_W*(1<<OFFSET_W)-1:0] line_in,
  input  logic                            wr_en,
  input  logic [OFFSET_W-1:0]             off,
  input  logic [WORD_W-1:0]               wdata,
  output logic [WORD_W*(1<<OFFSET_W)-1:0] line_out,
  output logic [WORD_W-1:0]               word_out
);
  localparam int WORDS = 1 << OFFSET_W;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign line_out[w*WORD_W +: WORD_W] =
      (wr_en && off == OFFSET_W'(w)) ? wdata : line_in[w*WORD_W +: WORD_W];
  end

  always_comb begin
    word_out = '0;
    for (int w = 0; w < WORDS; w++)
      if (off == OFFSET_W'(w)) word_out = line_out[w*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/hr_cache.sv
module hr_cache #(
  parameter int ADDR_W   = 12,
  parameter int INDEX_W  = 3,
  parameter int OFFSET_W = 1,
  parameter int WORD_W   = 32
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                req_valid,
  output logic                                req_ready,
  input  logic                                req_write,
  input  logic [ADDR_W-1:0]                   req_addr,
  input  logic [WORD_W-1:0]                   req_wdata,
  output logic                                resp_valid,
  output logic [WORD_W-1:0]                   resp_rdata,
  output logic                                mem_req,
  output logic                                mem_we,
  output logic [ADDR_W-OFFSET_W-1:0]          mem_addr,
  output logic [WORD_W*(1<<OFFSET_W)-1:0]     mem_wdata,
  input  logic                                mem_ack,
  input  logic [WORD_W*(1<<OFFSET_W)-1:0]     mem_rdata
);
  import hr_pkg::*;

  localparam int LINE_W  = WORD_W * (1 << OFFSET_W);
  localparam int TAG_W   = ADDR_W - INDEX_W - OFFSET_W;
  localparam int META_W  = TAG_W + FLAG_W;
  localparam logic [INDEX_W-1:0] TOP_MASK = {1'b1, {(INDEX_W-1){1'b0}}};

  hr_state_t st;
  logic                q_write;
  logic [TAG_W-1:0]    q_tag;
  logic [INDEX_W-1:0]  q_idx, r_idx;
  logic [OFFSET_W-1:0] q_off;
  logic [WORD_W-1:0]   q_wdata;

  logic [META_W-1:0] a_meta, b_meta, wa_meta, wb_meta;
  logic [LINE_W-1:0] a_data, b_data, src_line, merged;
  logic [WORD_W-1:0] merged_word;
  logic wa_en, wb_en, hit_p, hit_r, dirty_new;

  // partner slot: top index bit inverted
  assign r_idx = q_idx ^ TOP_MASK;

  wire             a_valid  = a_meta[META_W-1];
  wire             a_dirty  = a_meta[META_W-2];
  wire             a_parked = a_meta[META_W-3];
  wire [TAG_W-1:0] a_tag    = a_meta[TAG_W-1:0];
  wire             b_valid  = b_meta[META_W-1];
  wire             b_dirty  = b_meta[META_W-2];
  wire             b_parked = b_meta[META_W-3];
  wire [TAG_W-1:0] b_tag    = b_meta[TAG_W-1:0];

  hr_line_store #(.INDEX_W(INDEX_W), .META_W(META_W), .LINE_W(LINE_W)) store_i (
    .clk(clk), .rst(rst),
    .a_idx(q_idx), .a_meta(a_meta), .a_data(a_data),
    .b_idx(r_idx), .b_meta(b_meta), .b_data(b_data),
    .wa_en(wa_en), .wa_meta(wa_meta), .wa_data(merged),
    .wb_en(wb_en), .wb_meta(wb_meta), .wb_data(a_data)
  );

  hr_tag_cmp #(.TAG_W(TAG_W)) cmp_p_i (
    .line_valid(a_valid), .line_parked(a_parked), .line_tag(a_tag),
    .want_parked(1'b0), .want_tag(q_tag), .hit(hit_p)
  );

  hr_tag_cmp #(.TAG_W(TAG_W)) cmp_r_i (
    .line_valid(b_valid), .line_parked(b_parked), .line_tag(b_tag),
    .want_parked(1'b1), .want_tag(q_tag), .hit(hit_r)
  );

  always_comb begin
    unique case (st)
      ST_LOOK1: src_line = a_data;
      ST_SWAP:  src_line = b_data;
      default:  src_line = mem_rdata;
    endcase
  end

  hr_word_merge #(.WORD_W(WORD_W), .OFFSET_W(OFFSET_W)) merge_i (
    .line_in(src_line), .wr_en(q_write), .off(q_off), .wdata(q_wdata),
    .line_out(merged), .word_out(merged_word)
  );

  // primary slot takes the requested block; partner takes the old primary
  assign wa_en = (st == ST_LOOK1 && hit_p) || st == ST_SWAP || (st == ST_FILL && mem_ack);
  assign wb_en = st == ST_SWAP || (st == ST_FILL && mem_ack);
  assign dirty_new = q_write | (st == ST_LOOK1 && a_dirty) | (st == ST_SWAP && b_dirty);
  assign wa_meta = {1'b1, dirty_new, 1'b0, q_tag};
  assign wb_meta = {a_valid, a_dirty, ~a_parked, a_tag};

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      req_ready  <= 1'b1;
      resp_valid <= 1'b0;
      resp_rdata <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      q_write    <= 1'b0;
      q_tag      <= '0;
      q_idx      <= '0;
      q_off      <= '0;
      q_wdata    <= '0;
    end else begin
      resp_valid <= 1'b0;
      unique case (st)
        ST_IDLE: if (req_valid) begin
          q_write   <= req_write;
          q_off     <= req_addr[OFFSET_W-1:0];
          q_idx     <= req_addr[OFFSET_W +: INDEX_W];
          q_tag     <= req_addr[ADDR_W-1 -: TAG_W];
          q_wdata   <= req_wdata;
          req_ready <= 1'b0;
          st        <= ST_LOOK1;
        end
        ST_LOOK1: if (hit_p) begin
          resp_valid <= 1'b1;
          resp_rdata <= merged_word;
          req_ready  <= 1'b1;
          st         <= ST_IDLE;
        end else begin
          st <= ST_LOOK2;
        end
        ST_LOOK2: if (hit_r) begin
          st <= ST_SWAP;
        end else if (b_valid && b_dirty) begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= {b_tag, (b_parked ? q_idx : r_idx)};
          mem_wdata <= b_data;
          st        <= ST_WB;
        end else begin
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          mem_addr <= {q_tag, q_idx};
          st       <= ST_FILL;
        end
        ST_WB: if (mem_ack) begin
          mem_we   <= 1'b0;
          mem_addr <= {q_tag, q_idx};
          st       <= ST_FILL;
        end
        ST_FILL: if (mem_ack) begin
          mem_req    <= 1'b0;
          resp_valid <= 1'b1;
          resp_rdata <= merged_word;
          req_ready  <= 1'b1;
          st         <= ST_IDLE;
        end
        ST_SWAP: begin
          resp_valid <= 1'b1;
          resp_rdata <= merged_word;
          req_ready  <= 1'b1;
          st         <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R10
  resp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);
  // R10
  busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_we) && $stable(mem_addr));
  // R4
  swap_settle_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SWAP) |=> hit_p && !hit_r);
  // R5
  fill_settle_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FILL && mem_ack) |=> hit_p);
  // R5
  fill_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |-> mem_addr == {q_tag, q_idx});
  // R6
  wb_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_addr[INDEX_W-1:0] == q_idx) || (mem_addr[INDEX_W-1:0] == r_idx));
endmodule

// File: tb/hr_cache_tb_top.sv
module hr_cache_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12, INDEX_W = 3, OFFSET_W = 1, WORD_W = 32;
  localparam int LINE_W = WORD_W * 2;
  localparam int LADDR_W = ADDR_W - OFFSET_W;
  localparam int MEM_LAT = 4;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_ready, req_write = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [WORD_W-1:0] req_wdata = '0;
  logic resp_valid;
  logic [WORD_W-1:0] resp_rdata;
  logic mem_req, mem_we, mem_ack = 0;
  logic [LADDR_W-1:0] mem_addr;
  logic [LINE_W-1:0] mem_wdata, mem_rdata = '0;

  int checks = 0, errors = 0;
  int mem_reads = 0, mem_writes = 0;
  logic [LINE_W-1:0] mem_line [1 << LADDR_W];
  logic [WORD_W-1:0] ref_word [1 << ADDR_W];

  always #(CLK_PERIOD/2) clk = ~clk;

  hr_cache #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .OFFSET_W(OFFSET_W), .WORD_W(WORD_W)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [WORD_W-1:0] init_word(int a);
    return WORD_W'(32'h1000_0000 + a * 5 + 3);
  endfunction

  function automatic logic [ADDR_W-1:0] mk(int tag, int idx, int off);
    return ADDR_W'((tag << (INDEX_W + OFFSET_W)) | (idx << OFFSET_W) | off);
  endfunction

  // memory model: line-wide, fixed latency, one-cycle ack
  initial begin
    for (int l = 0; l < (1 << LADDR_W); l++)
      mem_line[l] = {init_word(2*l+1), init_word(2*l)};
    for (int a = 0; a < (1 << ADDR_W); a++) ref_word[a] = init_word(a);
    forever begin
      @(negedge clk);
      mem_ack = 0;
      if (mem_req) begin
        repeat (MEM_LAT-1) @(negedge clk);
        if (mem_we) begin
          mem_line[mem_addr] = mem_wdata;
          mem_writes++;
        end else begin
          mem_rdata = mem_line[mem_addr];
          mem_reads++;
        end
        mem_ack = 1;
        @(negedge clk);
        mem_ack = 0;
      end
    end
  end

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // issue one request; n = edges from acceptance edge to the response edge, inclusive
  task automatic access(bit wr, logic [ADDR_W-1:0] a, logic [WORD_W-1:0] wd,
                        output int n, output logic [WORD_W-1:0] rd);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd;
    n = 0; rd = '0;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); #1;
      req_valid = 0;
      n++;
      if (resp_valid) begin rd = resp_rdata; break; end
    end
    if (wr) ref_word[a] = wd;
  endtask

  task automatic rd_check(string req, logic [ADDR_W-1:0] a, int exp_n, bit exact);
    int n; logic [WORD_W-1:0] d;
    access(0, a, '0, n, d);
    check(d == ref_word[a], {req, " data"}, d, ref_word[a]);
    if (exact) check(n == exp_n, {req, " latency"}, n, exp_n);
    else check(n >= exp_n && n < 200, {req, " miss latency"}, n, exp_n);
  endtask

  task automatic t_reset();
    check(req_ready == 1, "R1 ready", req_ready, 1);
    check(resp_valid == 0, "R1 resp", resp_valid, 0);
    check(mem_req == 0, "R1 mem_req", mem_req, 0);
  endtask

  task automatic t_primary();
    int r0 = mem_reads;
    rd_check("R1 cold miss", mk(1,2,0), 5, 0);
    check(mem_reads == r0 + 1, "R5 fill count", mem_reads, r0 + 1);
    r0 = mem_reads;
    rd_check("R2 primary hit", mk(1,2,1), 2, 1);
    check(mem_reads == r0, "R2 no traffic", mem_reads, r0);
  endtask

  task automatic t_rehash_swap();
    rd_check("R5 conflict miss", mk(2,2,0), 5, 0);
    rd_check("R3 R4 partner hit", mk(1,2,0), 4, 1);
    rd_check("R4 after swap", mk(1,2,0), 2, 1);
    rd_check("R4 displaced hit", mk(2,2,1), 4, 1);
  endtask

  task automatic t_write_back();
    int n; logic [WORD_W-1:0] d; int w0, r0;
    access(1, mk(1,2,1), 32'hDEADBEEF, n, d);
    check(n == 4, "R8 write via partner", n, 4);
    rd_check("R8 write readback", mk(1,2,1), 2, 1);
    rd_check("R8 untouched word", mk(1,2,0), 2, 1);
    w0 = mem_writes;
    rd_check("R6 clean evict", mk(3,2,0), 5, 0);
    check(mem_writes == w0, "R6 no write clean", mem_writes, w0);
    rd_check("R6 dirty evict", mk(4,2,0), 5, 0);
    check(mem_writes == w0 + 1, "R6 write-back", mem_writes, w0 + 1);
    r0 = mem_reads;
    rd_check("R6 refetch written", mk(1,2,1), 5, 0);
    check(mem_reads == r0 + 1, "R6 refetch read", mem_reads, r0 + 1);
  endtask

  task automatic t_parked_flag();
    int r0 = mem_reads;
    rd_check("R7 same tag parked", mk(4,6,1), 5, 0);
    check(mem_reads == r0 + 1, "R7 no false hit", mem_reads, r0 + 1);
    rd_check("R7 moved home", mk(4,2,0), 2, 1);
    rd_check("R7 new line", mk(4,6,0), 2, 1);
  endtask

  task automatic t_write_miss();
    int n; logic [WORD_W-1:0] d; int r0 = mem_reads;
    access(1, mk(6,0,0), 32'h12345678, n, d);
    check(mem_reads == r0 + 1, "R8 write miss fetch", mem_reads, r0 + 1);
    check(d == 32'h12345678, "R8 write resp", d, 32'h12345678);
    rd_check("R8 merged word", mk(6,0,0), 2, 1);
    rd_check("R8 neighbour kept", mk(6,0,1), 2, 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_primary();
        t_rehash_swap();
        t_write_back();
        t_parked_flag();
        t_write_miss();
      end
      begin
        #(CLK_PERIOD * 100000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule